// File: doc/BRIEF.md
# Dual-Edge Programmable Frequency Divider

This block divides a slow square wave by a programmable integer N. Every transition of the input, rising or falling, counts as one step. The output flips each time N steps have gone by, so one full output period spans 2N transitions, which is N input periods. A typical use is the feedback path of a frequency synthesizer, where the oscillator output is divided back down to the reference rate.

The input is brought into the system clock domain through a flop chain. A transition turns into a single-cycle enable pulse. That pulse advances a counter. The count is then copied into a registered stage bank, and an equality compare against the active divisor both reloads the counter and flips the output. A new divisor is adopted only at a flip, so the half-period in progress always runs to completion. The live count is also brought out as a debug value.

Top module: `fdiv_top`

## Requirements
- R1: While `rst_n` is low, `div_out` is 0 and `count_dbg` is 0.
- R2: Each input transition, rising or falling, raises `count_dbg` by exactly one, provided each input level is held for at least 4 clock cycles.
- R3: `div_out` flips exactly once every N input transitions, so its period is N input periods.
- R4: In the cycle where `div_out` flips, `count_dbg` returns to 0. Between flips, it reads the number of transitions seen since the last flip.
- R5: `count_dbg` never exceeds the active divisor.
- R6: A change on `div_n` has no effect until the next flip of `div_out`. The half-period in progress keeps the old divisor.
- R7: The values 0 and 1 on `div_n` act as a divisor of 2.
- R8: Every divisor from 2 to 127 works, including both extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of every flop |
| sq_in | input | 1 | Square wave to divide; asynchronous to `clk` |
| div_n | input | 7 | Divisor N, unsigned binary |
| div_out | output | 1 | Divided square wave |
| count_dbg | output | 7 | Transitions counted since the last output flip |

## Verification
Several internal faults show up directly at the ports:
- A counter that misses or doubles a step shows on `count_dbg` at the very next transition. This is about 5 clock cycles after the input changes.
- A compare against the wrong value, or a divisor taken at the wrong moment, moves the flip of `div_out` by at least one transition. A reference model in the bench exposes this within one half-period.
- A divisor floor that fails lets `div_out` flip after a single transition, or never flip at all.

Each of these is caught before the next input transition is driven.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

   // Smallest divisor the block accepts; lower requests are raised to it.
   localparam int unsigned FDIV_MIN_N = 2;

   function automatic int unsigned fdiv_floor(input int unsigned n, input int unsigned lo);
      return (n < lo) ? lo : n;
   endfunction

endpackage

// File: rtl/fdiv_edge_det.sv
module fdiv_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sq_in,
   output logic edge_stb
);
   localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fdiv_edge_det: SYNC_STAGES must be at least 2");
   end

   // chain[0..SYNC_STAGES-1] synchronise; chain[SYNC_STAGES] keeps the prior level
   logic [CHAIN_W-1:0] chain;
   logic               stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         stb_q <= 1'b0;
      end else begin
         chain <= {chain[CHAIN_W-2:0], sq_in};
         stb_q <= chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
      end
   end

   assign edge_stb = stb_q;

endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             reload,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (reload) cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R2: one step advances the count by exactly one
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !reload) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R4: a reload leaves the count at zero
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt_q == '0));

endmodule

// File: rtl/fdiv_stage_bank.sv
module fdiv_stage_bank #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [CNT_W-1:0] d,
   output logic [CNT_W-1:0] q
);
   // One flop per bit, all sharing the capture enable
   for (genvar b = 0; b < CNT_W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       bit_q <= 1'b0;
         else if (capture) bit_q <= d[b];
      end
      assign q[b] = bit_q;
   end

endmodule

// File: rtl/fdiv_match.sv
module fdiv_match
   import fdiv_pkg::*;
#(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [CNT_W-1:0] held,
   input  logic [CNT_W-1:0] div_n,
   output logic             hit,
   output logic             primed,
   output logic [CNT_W-1:0] n_act,
   output logic             div_out
);
   localparam logic [CNT_W-1:0] MIN_N = CNT_W'(FDIV_MIN_N);

   logic [CNT_W-1:0] n_floor;
   logic [CNT_W-1:0] n_q;
   logic             primed_q;
   logic             out_q;

   assign n_floor = CNT_W'(fdiv_floor(32'(div_n), FDIV_MIN_N));
   assign hit     = strobe && primed_q && (held == n_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q      <= '0;
         primed_q <= 1'b0;
         out_q    <= 1'b0;
      end else if (!primed_q) begin
         n_q      <= n_floor;
         primed_q <= 1'b1;
      end else if (hit) begin
         n_q   <= n_floor;
         out_q <= ~out_q;
      end
   end

   assign n_act   = n_q;
   assign primed  = primed_q;
   assign div_out = out_q;

   // R6: the active divisor only moves at a match
   p_hold_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !hit) |=> $stable(n_q));

   // R7: once loaded, the divisor is never below the floor
   p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> (n_q >= MIN_N));

endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
   import fdiv_pkg::*;
#(
   parameter int unsigned CNT_W       = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sq_in,
   input  logic [CNT_W-1:0] div_n,
   output logic             div_out,
   output logic [CNT_W-1:0] count_dbg
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("fdiv_top: CNT_W must lie in 2..16");
   end
   if (FDIV_MIN_N >= (1 << CNT_W)) begin : g_bad_floor
      $error("fdiv_top: divisor floor does not fit CNT_W");
   end

   logic             edge_stb;
   logic             cap_stb;
   logic             cmp_stb;
   logic             hit;
   logic             primed;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] held;
   logic [CNT_W-1:0] n_act;

   fdiv_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .sq_in(sq_in), .edge_stb(edge_stb));

   fdiv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(edge_stb), .reload(hit), .cnt(cnt));

   // Pulse pipeline: capture one cycle after the step, compare one after that
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_stb <= 1'b0;
         cmp_stb <= 1'b0;
      end else begin
         cap_stb <= edge_stb;
         cmp_stb <= cap_stb;
      end
   end

   fdiv_stage_bank #(.CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .capture(cap_stb), .d(cnt), .q(held));

   fdiv_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .strobe(cmp_stb), .held(held), .div_n(div_n),
      .hit(hit), .primed(primed), .n_act(n_act), .div_out(div_out));

   assign count_dbg = cnt;

   // R5: the count stays within the active divisor
   p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (cnt <= n_act));

   // R3: the output only flips when the count had reached the divisor
   p_flip_at_n_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (div_out != $past(div_out)) |-> ($past(cnt) == $past(n_act)));

endmodule

// File: tb/sim_fdiv_top.sv
module sim_fdiv_top;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sq_in = 1'b0;
   logic [6:0] div_n = 7'd2;
   logic       div_out;
   logic [6:0] count_dbg;

   int checks = 0;
   int fails  = 0;
   int exp_cnt;
   int n_active;
   logic exp_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   fdiv_top u0 (.clk(clk), .rst_n(rst_n), .sq_in(sq_in), .div_n(div_n),
                .div_out(div_out), .count_dbg(count_dbg));

   function automatic int floor2(input int n);
      return (n < 2) ? 2 : n;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic t_reset(input int n);
      @(negedge clk);
      rst_n = 1'b0;
      sq_in = 1'b0;
      div_n = 7'(n);
      repeat (3) @(negedge clk);
      chk(div_out == 1'b0, "R1", int'(div_out), 0);
      chk(count_dbg == 7'd0, "R1", int'(count_dbg), 0);
      rst_n = 1'b1;
      n_active = floor2(n);
      exp_cnt = 0;
      exp_out = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // One input transition, then compare the ports with the model
   task automatic do_edge(input string req);
      bit flipped;
      @(negedge clk);
      sq_in = ~sq_in;
      repeat (SETTLE) @(negedge clk);
      flipped = 1'b0;
      exp_cnt++;
      if (exp_cnt == n_active) begin
         exp_out  = ~exp_out;
         exp_cnt  = 0;
         n_active = floor2(int'(div_n));
         flipped  = 1'b1;
      end
      chk(div_out == exp_out, req, int'(div_out), int'(exp_out));
      chk(int'(count_dbg) == exp_cnt, req, int'(count_dbg), exp_cnt);
      chk(int'(count_dbg) <= n_active, "R5", int'(count_dbg), n_active);
      if (flipped) chk(count_dbg == 7'd0, "R4", int'(count_dbg), 0);
   endtask

   task automatic t_count;
      t_reset(50);
      for (int i = 0; i < 12; i++) do_edge("R2");
   endtask

   task automatic t_divide(input int n);
      t_reset(n);
      for (int i = 0; i < 2*n + 1; i++) do_edge("R3");
   endtask

   task automatic t_change;
      t_reset(20);
      for (int i = 0; i < 5; i++) do_edge("R6");
      div_n = 7'd4;
      for (int i = 0; i < 15; i++) do_edge("R6");
      for (int i = 0; i < 9; i++) do_edge("R6");
   endtask

   task automatic t_low;
      t_reset(0);
      for (int i = 0; i < 7; i++) do_edge("R7");
      div_n = 7'd1;
      for (int i = 0; i < 7; i++) do_edge("R7");
   endtask

   task automatic t_extremes;
      t_reset(2);
      for (int i = 0; i < 6; i++) do_edge("R8");
      t_reset(127);
      for (int i = 0; i < 2*127 + 2; i++) do_edge("R8");
   endtask

   initial begin
      t_count();
      t_divide(5);
      t_divide(9);
      t_divide(90);
      t_change();
      t_low();
      t_extremes();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule